// File: doc/BRIEF.md
# Scan-based roll-forward recovery controller

This controller sits beside five identical redundant modules, each with a serial scan chain. While the system runs normally, the controller stays idle and the scan chains are off. When the voter reports any disagreement, the controller starts a comparison pass. Scan is switched on for exactly `CHAIN_LEN` cycles, and every module's state is rotated once through its own chain. During that pass, ten pairwise counters record how often each pair of serial outputs differs. A locator then decides which modules are faulty. A second pass of the same length, the recovery pass, reloads every faulty module's chain from one healthy module. Healthy chains loop back onto themselves, so their state is unchanged.

The recovery pass replays the same comparisons, and each pairwise counter counts down on every mismatch. If all ten counters are back at zero when the pass ends, the repair took place without a new upset and the controller returns to normal. Otherwise it enters a halt state for fail-safe shutdown, and it also halts when the comparison pass cannot produce a usable repair plan. The scan data path is a lock-step bit stream with no valid/ready handshake and no back-pressure. Every cycle with scan enable high moves exactly one bit through every chain, and a mismatch can only be counted in that same cycle.

Top module: `fmr_scan_recovery_ctrl`

## Requirements
- R1: After reset the controller is in the normal state. Scan enable is low, the fault vector is 00000, and every routing select points at its own module.
- R2: A high `any_err_i` while in the normal state moves the controller to the comparison state on the next clock edge. `any_err_i` has no effect in any other state.
- R3: Scan enable is high in the comparison and recovery states and low otherwise. Each of the two passes lasts exactly `CHAIN_LEN` cycles.
- R4: A module is marked faulty when at least three of the four pairwise counters that involve it are nonzero after the comparison pass. The fault vector holds module k in bit k-1, so module 1 is the LSB and module 3 alone reads 00100. The vector is loaded at the end of the comparison pass and cleared when a new comparison starts.
- R5: `sci_sel_o[3k-1:3k-3]` selects the source for module k's scan input, with value j-1 meaning module j. During recovery a faulty module selects the lowest-numbered unmarked module. In every other case each module selects itself.
- R6: `sci_o[k-1]` always equals the `sco_i` bit of the module named by module k's select field.
- R7: If the comparison pass marks no module, or marks all five, the controller enters the halt state.
- R8: If all ten counters are zero when the recovery pass ends, the controller returns to normal. Every chain then holds the fault-free content, including when two faulty modules carry the same wrong bit.
- R9: A mismatch count that is left nonzero at the end of recovery, for example from an upset during the recovery pass, sends the controller to halt.
- R10: The halt state is left only through reset. While halted, scan enable stays low and `any_err_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| any_err_i | input | 1 | OR of the voter's pairwise disagreement flags |
| sco_i | input | 5 | Serial scan outputs of modules 1..5 (bit k-1 = module k) |
| scan_en_o | output | 1 | Shift enable shared by all five scan chains |
| sci_o | output | 5 | Routed serial scan inputs for modules 1..5 |
| sci_sel_o | output | 15 | Per-module 3-bit source select, field k-1 for module k |
| fault_o | output | 5 | Located faulty modules, bit k-1 = module k |
| st_normal_o | output | 1 | Normal state flag |
| st_compare_o | output | 1 | Comparison pass flag |
| st_recover_o | output | 1 | Recovery pass flag |
| st_halt_o | output | 1 | Unrecoverable halt flag |

## Verification
The bench targets four corner cases:
- Two modules that carry the same wrong bit. A controller that dropped the pair between them would fail to mark one of the two modules, and that module would keep its corrupt state.
- Three distinct faults, which mark all five modules, and a false alarm, which marks none. Both must halt. A controller that recovered here would reload from a broken source or spin uselessly.
- An upset injected into a healthy chain halfway through recovery. This must leave a nonzero count and force a halt rather than a silent return to normal.
- Error pulses during a pass and while halted. These must change nothing, and a controller that restarted on them would corrupt the pass timing.

// File: rtl/fmr_pkg.sv
package fmr_pkg;
  localparam int NMOD  = 5;
  localparam int NPAIR = NMOD * (NMOD - 1) / 2;
  localparam int IDXW  = $clog2(NMOD);

  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_COMPARE = 2'd1,
    ST_RECOVER = 2'd2,
    ST_HALT    = 2'd3
  } ctl_state_e;

  // lower module index of pair p, pairs enumerated (0,1),(0,2)...(3,4)
  function automatic int pair_lo(input int p);
    int k;
    k = 0;
    pair_lo = 0;
    for (int i = 0; i < NMOD; i++)
      for (int j = i + 1; j < NMOD; j++) begin
        if (k == p) pair_lo = i;
        k++;
      end
  endfunction

  function automatic int pair_hi(input int p);
    int k;
    k = 0;
    pair_hi = 0;
    for (int i = 0; i < NMOD; i++)
      for (int j = i + 1; j < NMOD; j++) begin
        if (k == p) pair_hi = j;
        k++;
      end
  endfunction
endpackage

// File: rtl/fmr_pair_counters.sv
module fmr_pair_counters
  import fmr_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             up,
  input  logic             down,
  input  logic [NMOD-1:0]  sco,
  output logic [NPAIR-1:0] nz_next
);
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    localparam int A = pair_lo(p);
    localparam int B = pair_hi(p);
    logic [CW-1:0] cnt_q, cnt_d;
    logic          diff;

    assign diff = sco[A] ^ sco[B];

    always_comb begin
      cnt_d = cnt_q;
      if (clear)             cnt_d = '0;
      else if (diff && up)   cnt_d = cnt_q + 1'b1;
      else if (diff && down) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign nz_next[p] = |cnt_d;

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(up && diff && (&cnt_q)));
  end
endmodule

// File: rtl/fmr_fault_locator.sv
module fmr_fault_locator
  import fmr_pkg::*;
(
  input  logic [NPAIR-1:0] nz,
  output logic [NMOD-1:0]  mask,
  output logic [IDXW-1:0]  src,
  output logic             src_ok
);
  always_comb begin
    for (int m = 0; m < NMOD; m++) begin
      int hits;
      hits = 0;
      for (int p = 0; p < NPAIR; p++)
        if (nz[p] && (pair_lo(p) == m || pair_hi(p) == m)) hits++;
      mask[m] = (hits >= 3);
    end
  end

  always_comb begin
    src = '0;
    for (int m = NMOD - 1; m >= 0; m--)
      if (!mask[m]) src = IDXW'(m);
    src_ok = ~&mask;
  end
endmodule

// File: rtl/fmr_sci_router.sv
module fmr_sci_router
  import fmr_pkg::*;
(
  input  logic                 recover,
  input  logic [NMOD-1:0]      fault,
  input  logic [IDXW-1:0]      src,
  input  logic [NMOD-1:0]      sco,
  output logic [NMOD*IDXW-1:0] sel,
  output logic [NMOD-1:0]      sci
);
  for (genvar m = 0; m < NMOD; m++) begin : g_mod
    logic [IDXW-1:0] s;
    assign s = (recover && fault[m]) ? src : IDXW'(m);
    assign sel[m*IDXW +: IDXW] = s;
    assign sci[m] = sco[s];
  end
endmodule

// File: rtl/fmr_scan_recovery_ctrl.sv
module fmr_scan_recovery_ctrl
  import fmr_pkg::*;
#(
  parameter int CHAIN_LEN = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         any_err_i,
  input  logic [4:0]   sco_i,
  output logic         scan_en_o,
  output logic [4:0]   sci_o,
  output logic [14:0]  sci_sel_o,
  output logic [4:0]   fault_o,
  output logic         st_normal_o,
  output logic         st_compare_o,
  output logic         st_recover_o,
  output logic         st_halt_o
);
  localparam int BW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam int CW = $clog2(CHAIN_LEN + 1);
  localparam logic [BW-1:0] LAST = BW'(CHAIN_LEN - 1);

  ctl_state_e      state;
  logic [BW-1:0]   bit_cnt;
  logic [NMOD-1:0] fault_r;
  logic [IDXW-1:0] src_r;
  logic [NPAIR-1:0] nz;
  logic [NMOD-1:0] mask;
  logic [IDXW-1:0] src;
  logic            src_ok;
  logic            last;
  logic            start;

  assign last  = (bit_cnt == LAST);
  assign start = (state == ST_NORMAL) && any_err_i;

  fmr_pair_counters #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start),
    .up      (state == ST_COMPARE),
    .down    (state == ST_RECOVER),
    .sco     (sco_i),
    .nz_next (nz)
  );

  fmr_fault_locator u_loc (
    .nz     (nz),
    .mask   (mask),
    .src    (src),
    .src_ok (src_ok)
  );

  fmr_sci_router u_rt (
    .recover (state == ST_RECOVER),
    .fault   (fault_r),
    .src     (src_r),
    .sco     (sco_i),
    .sel     (sci_sel_o),
    .sci     (sci_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_NORMAL;
      bit_cnt <= '0;
      fault_r <= '0;
      src_r   <= '0;
    end else begin
      unique case (state)
        ST_NORMAL: if (any_err_i) begin
          state   <= ST_COMPARE;
          bit_cnt <= '0;
          fault_r <= '0;
        end
        ST_COMPARE: if (last) begin
          bit_cnt <= '0;
          fault_r <= mask;
          src_r   <= src;
          state   <= ((|mask) && src_ok) ? ST_RECOVER : ST_HALT;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
        ST_RECOVER: if (last) begin
          bit_cnt <= '0;
          state   <= (|nz) ? ST_HALT : ST_NORMAL;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  assign scan_en_o    = (state == ST_COMPARE) || (state == ST_RECOVER);
  assign fault_o      = fault_r;
  assign st_normal_o  = (state == ST_NORMAL);
  assign st_compare_o = (state == ST_COMPARE);
  assign st_recover_o = (state == ST_RECOVER);
  assign st_halt_o    = (state == ST_HALT);

  // R2
  trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NORMAL && any_err_i) |=> (state == ST_COMPARE));

  // R3
  pass_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COMPARE && last) |=> (state != ST_COMPARE));

  // R7
  recover_plan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECOVER) |-> ((|fault_r) && !(&fault_r)));

  // R5
  source_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECOVER) |-> !fault_r[src_r]);

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT) |=> (state == ST_HALT && $stable(fault_r)));
endmodule

// File: tb/tb_fmr_scan_recovery_ctrl.sv
module tb_fmr_scan_recovery_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam logic [N-1:0] PAT = N'(64'h9E3779B97F4A7C15);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        any_err_i = 1'b0;
  logic [4:0]  sco_i;
  logic        scan_en_o;
  logic [4:0]  sci_o;
  logic [14:0] sci_sel_o;
  logic [4:0]  fault_o;
  logic        st_normal_o, st_compare_o, st_recover_o, st_halt_o;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fmr_scan_recovery_ctrl #(.CHAIN_LEN(N)) dut (
    .clk(clk), .rst_n(rst_n), .any_err_i(any_err_i), .sco_i(sco_i),
    .scan_en_o(scan_en_o), .sci_o(sci_o), .sci_sel_o(sci_sel_o),
    .fault_o(fault_o), .st_normal_o(st_normal_o), .st_compare_o(st_compare_o),
    .st_recover_o(st_recover_o), .st_halt_o(st_halt_o)
  );

  // behavioural scan chains of the five modules
  logic [N-1:0] ch [5];
  logic [N-1:0] inj [5];
  logic         inj_go = 1'b0;

  always_comb for (int m = 0; m < 5; m++) sco_i[m] = ch[m][0];

  always @(posedge clk) begin
    logic [N-1:0] nxt;
    for (int m = 0; m < 5; m++) begin
      if (!rst_n) ch[m] <= PAT;
      else begin
        nxt = scan_en_o ? {sci_o[m], ch[m][N-1:1]} : ch[m];
        if (inj_go) nxt = nxt ^ inj[m];
        ch[m] <= nxt;
      end
    end
  end

  // reference model: 0 normal, 1 compare, 2 recover, 3 halt
  int         m_st = 0;
  int         m_bit = 0;
  int         mm [5][5];
  logic [4:0] m_fault = '0;
  int         m_src = 0;
  bit         started = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_bit = 0; m_fault = '0; m_src = 0; started = 1;
      for (int i = 0; i < 5; i++) for (int j = 0; j < 5; j++) mm[i][j] = 0;
    end else begin
      case (m_st)
        0: if (any_err_i) begin
          m_st = 1; m_bit = 0; m_fault = '0;
          for (int i = 0; i < 5; i++) for (int j = 0; j < 5; j++) mm[i][j] = 0;
        end
        1, 2: begin
          for (int i = 0; i < 5; i++)
            for (int j = i + 1; j < 5; j++)
              if (sco_i[i] != sco_i[j]) mm[i][j] += (m_st == 1) ? 1 : -1;
          if (m_bit == N - 1) begin
            m_bit = 0;
            if (m_st == 1) begin
              logic [4:0] mk;
              mk = '0;
              for (int k = 0; k < 5; k++) begin
                int h;
                h = 0;
                for (int o = 0; o < 5; o++)
                  if (o != k && mm[(k < o) ? k : o][(k < o) ? o : k] != 0) h++;
                mk[k] = (h >= 3);
              end
              m_fault = mk;
              m_src = 0;
              while (m_src < 5 && mk[m_src]) m_src++;
              m_st = (mk == 0 || mk == 5'b11111) ? 3 : 2;
            end else begin
              bit bad;
              bad = 0;
              for (int i = 0; i < 5; i++)
                for (int j = i + 1; j < 5; j++) if (mm[i][j] != 0) bad = 1;
              m_st = bad ? 3 : 0;
            end
          end else m_bit++;
        end
        default: m_st = 3;
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      chk(scan_en_o == (m_st == 1 || m_st == 2), "R3 scan_en", scan_en_o, (m_st == 1 || m_st == 2));
      chk({st_normal_o, st_compare_o, st_recover_o, st_halt_o} ==
          {m_st == 0, m_st == 1, m_st == 2, m_st == 3}, "R2/R10 state flags",
          {st_normal_o, st_compare_o, st_recover_o, st_halt_o}, m_st);
      chk(fault_o == m_fault, "R4 fault vector", fault_o, m_fault);
      for (int m = 0; m < 5; m++) begin
        int es;
        es = (m_st == 2 && m_fault[m]) ? m_src : m;
        chk(int'(sci_sel_o[3*m +: 3]) == es, "R5 select", sci_sel_o[3*m +: 3], es);
        chk(sci_o[m] == sco_i[es], "R6 routed sci", sci_o[m], sco_i[es]);
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; any_err_i = 1'b0;
    cycles(2);
    rst_n = 1'b1;
  endtask

  task automatic inject(input int m, input int pos);
    @(negedge clk);
    for (int k = 0; k < 5; k++) inj[k] = '0;
    inj[m] = N'(1) << pos;
    inj_go = 1'b1;
    @(negedge clk);
    inj_go = 1'b0;
    inj[m] = '0;
  endtask

  task automatic pulse_err();
    @(negedge clk); any_err_i = 1'b1;
    @(negedge clk); any_err_i = 1'b0;
  endtask

  task automatic expect_end(input string req, input bit halt, input logic [4:0] f);
    chk(st_halt_o == halt && st_normal_o == !halt, req, {st_normal_o, st_halt_o}, {!halt, halt});
    chk(fault_o == f, req, fault_o, f);
  endtask

  task automatic chains_clean(input string req);
    for (int m = 0; m < 5; m++) chk(ch[m] == PAT, req, ch[m], PAT);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int k = 0; k < 5; k++) inj[k] = '0;
    cycles(3);
    rst_n = 1'b1;
    // R1 reset state
    chk(st_normal_o && !scan_en_o && fault_o == 5'b0 && sci_sel_o == 15'o43210,
        "R1 reset", sci_sel_o, 15'o43210);

    // single faulty module 3 -> 00100
    inject(2, 5); pulse_err(); cycles(2 * N + 4);
    expect_end("R4 R8 single fault", 1'b0, 5'b00100);
    chains_clean("R8 single restored");

    // modules 1 and 3, distinct bits -> 00101
    do_reset(); inject(0, 3); inject(2, 9); pulse_err(); cycles(2 * N + 4);
    expect_end("R4 R8 two faults", 1'b0, 5'b00101);
    chains_clean("R8 two restored");

    // modules 1 and 3 flipped on the same bit
    do_reset(); inject(0, 7); inject(2, 7); pulse_err(); cycles(2 * N + 4);
    expect_end("R4 R8 common bit", 1'b0, 5'b00101);
    chains_clean("R8 common restored");

    // error pulses during a pass are ignored, module 4 -> 01000
    do_reset(); inject(3, 1); pulse_err(); cycles(3); pulse_err(); cycles(2 * N + 4);
    expect_end("R2 ignore in pass", 1'b0, 5'b01000);
    chains_clean("R2 restored");

    // three distinct faults mark all five modules
    do_reset(); inject(0, 2); inject(1, 6); inject(2, 11); pulse_err(); cycles(N + 4);
    expect_end("R7 all marked", 1'b1, 5'b11111);

    // false alarm, then halt must hold
    do_reset(); pulse_err(); cycles(N + 4);
    expect_end("R7 none marked", 1'b1, 5'b00000);
    pulse_err(); cycles(N);
    chk(st_halt_o && !scan_en_o, "R10 sticky halt", {st_halt_o, scan_en_o}, 2'b10);

    // upset in a healthy chain during recovery
    do_reset(); inject(1, 4); pulse_err(); cycles(N + 4);
    chk(st_recover_o, "R9 in recovery", st_recover_o, 1);
    inject(4, 2); cycles(N + 4);
    expect_end("R9 upset during recovery", 1'b1, 5'b00010);

    do_reset(); cycles(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule